// File: doc/BRIEF.md
# Toggle-Start Stopwatch

This block is a stopwatch that keeps hours, minutes and seconds. A fast system clock goes through a prescaler and then a compare counter, and together they produce exactly one pulse per second of run time. That pulse steps a seconds field. The seconds field carries into a minutes field, and the minutes field carries into an hours field. All three fields wrap, and the hours field returns to zero after 23.

Two push-button inputs control the block. The first button flips the stopwatch between running and paused. While paused, every counter holds its value, including the prescaler and the compare counter. When counting resumes, it continues from exactly where it stopped. The second button clears the prescaler, the compare counter and all three time fields on one clock edge. Each button goes through a two-flop synchronizer, and only a rising edge of the synchronized level counts as a press. The outputs are the three fields in binary and a running flag. After reset the stopwatch is stopped at 00:00:00.

Top module: `sw_stopwatch`

## Requirements
- R1: After `rst_n` is released, `hours`, `minutes` and `seconds` read 0 and `running` is 0. The fields stay at 0 until a toggle press starts the count.
- R2: One second equals `PRE_DIV` × `TICKS` clock cycles spent running (8 MHz / 256 = 31250 compare counts by default). The prescaler wraps at `PRE_DIV`−1. The compare counter advances on each prescaler wrap and clears when it matches `TICKS`−1. `seconds` steps on the edge that completes the last running cycle of the second.
- R3: A toggle press flips `running`. The flag changes on the third rising clock edge at which `btn_toggle` is sampled high.
- R4: While `running` is 0, all fields hold, and so does the fraction of the current second. After resume, the next step of `seconds` comes when the unfinished part of that second has run.
- R5: A clear press sets all three fields, the prescaler and the compare counter to zero on the third rising edge at which `btn_clear` is sampled high. `running` is left unchanged.
- R6: `seconds` steps from 59 to 0 and adds one to `minutes` on the same edge.
- R7: `minutes` steps from 59 to 0 and adds one to `hours` on the same edge.
- R8: `hours` steps from 23 to 0 when minutes and seconds roll over, so 23:59:59 is followed by 00:00:00.
- R9: When clear and toggle presses land on the same cycle, the clear takes effect and the toggle is ignored, so `running` keeps its value.
- R10: A button held high for many cycles counts as one press. Holding the toggle button flips `running` once only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| btn_toggle | input | 1 | Run/pause button level, asynchronous |
| btn_clear | input | 1 | Clear button level, asynchronous |
| hours | output | 5 | Hours field, 0 to 23 |
| minutes | output | 6 | Minutes field, 0 to 59 |
| seconds | output | 6 | Seconds field, 0 to 59 |
| running | output | 1 | 1 while the stopwatch counts |

## Verification
The assertions assume the block leaves reset before any press is seen. They also assume both button inputs are registered through the synchronizers, so a press pulse lasts exactly one cycle. The bench changes button levels only on falling clock edges and holds each press for at least three cycles. It leaves time between presses for the edge detector to see the level low again. To fit the run inside the cycle budget, the bench shortens the second by overriding the prescale and compare parameters. A second instance with a one-cycle second walks through a whole day, so the hours wrap is reached.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int SEC_LIMIT = 60;
    localparam int MIN_LIMIT = 60;
    localparam int HR_LIMIT  = 24;

    localparam int SEC_W = $clog2(SEC_LIMIT);
    localparam int MIN_W = $clog2(MIN_LIMIT);
    localparam int HR_W  = $clog2(HR_LIMIT);

    localparam int BTN_TOG = 0;
    localparam int BTN_CLR = 1;
    localparam int BTN_N   = 2;

    typedef struct packed {
        logic run;
    } sw_ctrl_t;

endpackage

// File: rtl/sw_btn_edge.sv
module sw_btn_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic press
);

    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d  = {sh_q[STAGES-1:0], btn};
        press = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
    parameter int PRE_DIV = 256,
    parameter int TICKS   = 31250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic sec_tick
);

    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [TW-1:0] tk;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic pre_wrap, tick_match;

    always_comb begin
        st_d       = st_q;
        pre_wrap   = (st_q.pre == PRE_LAST);
        tick_match = (st_q.tk == TICK_LAST);
        sec_tick   = en && !clr && pre_wrap && tick_match;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            if (pre_wrap) begin
                st_d.pre = '0;
                st_d.tk  = tick_match ? '0 : st_q.tk + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sw_wrap_counter.sv
module sw_wrap_counter #(
    parameter int LIMIT = 60,
    parameter int W     = $clog2(LIMIT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);

    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        carry = inc && !clr && (val_q == LAST);
        if (clr)        val_d = '0;
        else if (carry) val_d = '0;
        else if (inc)   val_d = val_q + 1'b1;
        val = val_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

endmodule

// File: rtl/sw_stopwatch.sv
module sw_stopwatch
    import sw_pkg::*;
#(
    parameter int PRE_DIV = 256,
    parameter int TICKS   = 31250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_toggle,
    input  logic             btn_clear,
    output logic [HR_W-1:0]  hours,
    output logic [MIN_W-1:0] minutes,
    output logic [SEC_W-1:0] seconds,
    output logic             running
);

    logic [BTN_N-1:0] btn_raw, btn_press;
    logic tog_pulse, clr_pulse;
    logic sec_tick, sec_carry, min_carry, hr_carry;
    sw_ctrl_t ctl_d, ctl_q;

    assign btn_raw[BTN_TOG] = btn_toggle;
    assign btn_raw[BTN_CLR] = btn_clear;

    genvar gi;
    generate
        for (gi = 0; gi < BTN_N; gi++) begin : g_btn
            sw_btn_edge #(.STAGES(2)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .btn  (btn_raw[gi]),
                .press(btn_press[gi])
            );
        end
    endgenerate

    assign tog_pulse = btn_press[BTN_TOG];
    assign clr_pulse = btn_press[BTN_CLR];

    always_comb begin
        ctl_d = ctl_q;
        if (tog_pulse && !clr_pulse) ctl_d.run = ~ctl_q.run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign running = ctl_q.run;

    sw_tick_gen #(.PRE_DIV(PRE_DIV), .TICKS(TICKS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_q.run),
        .clr     (clr_pulse),
        .sec_tick(sec_tick)
    );

    sw_wrap_counter #(.LIMIT(SEC_LIMIT), .W(SEC_W)) u_sec (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_pulse),
        .inc  (sec_tick),
        .val  (seconds),
        .carry(sec_carry)
    );

    sw_wrap_counter #(.LIMIT(MIN_LIMIT), .W(MIN_W)) u_min (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_pulse),
        .inc  (sec_carry),
        .val  (minutes),
        .carry(min_carry)
    );

    sw_wrap_counter #(.LIMIT(HR_LIMIT), .W(HR_W)) u_hr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_pulse),
        .inc  (min_carry),
        .val  (hours),
        .carry(hr_carry)
    );

endmodule

// File: rtl/sw_stopwatch_chk.sv
module sw_stopwatch_chk
    import sw_pkg::*;
#(
    parameter int PRE_DIV = 256,
    parameter int TICKS   = 31250
) (
    input logic             clk,
    input logic             rst_n,
    input logic [HR_W-1:0]  hours,
    input logic [MIN_W-1:0] minutes,
    input logic [SEC_W-1:0] seconds,
    input logic             running,
    input logic             tog_pulse,
    input logic             clr_pulse,
    input logic             sec_tick,
    input logic             sec_carry,
    input logic             min_carry,
    input logic             hr_carry
);

    localparam int PERIOD = PRE_DIV * TICKS;

    int run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                    run_cnt <= 0;
        else if (clr_pulse)            run_cnt <= 0;
        else if (running && sec_tick)  run_cnt <= 0;
        else if (running)              run_cnt <= run_cnt + 1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (run_cnt == PERIOD - 1)); // R2

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_pulse && !clr_pulse) |=> (running != $past(running))); // R3

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clr_pulse) |=> $stable({hours, minutes, seconds})); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (hours == 0 && minutes == 0 && seconds == 0)); // R5

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && seconds == SEC_W'(SEC_LIMIT - 1)) |=> (seconds == 0)); // R6

    AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_carry && minutes != MIN_W'(MIN_LIMIT - 1)) |=> (minutes == $past(minutes) + 1'b1)); // R7

    AST_HR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        hr_carry |=> (hours == 0)); // R8

    AST_HR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (min_carry && !hr_carry) |=> (hours == $past(hours) + 1'b1)); // R8

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_pulse && clr_pulse) |=> (running == $past(running))); // R9

    AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seconds < SEC_LIMIT) && (minutes < MIN_LIMIT) && (hours < HR_LIMIT)); // R6

endmodule

bind sw_stopwatch sw_stopwatch_chk #(.PRE_DIV(PRE_DIV), .TICKS(TICKS)) u_chk (.*);

// File: tb/sw_stopwatch_tb.sv
module sw_stopwatch_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_tog = 1'b0, a_clr = 1'b0;
    logic b_tog = 1'b0, b_clr = 1'b0;
    logic [4:0] a_hr, b_hr;
    logic [5:0] a_mn, a_sc, b_mn, b_sc;
    logic a_run, b_run;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // main instance: 12 running cycles per second
    sw_stopwatch #(.PRE_DIV(4), .TICKS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_toggle(a_tog), .btn_clear(a_clr),
        .hours(a_hr), .minutes(a_mn), .seconds(a_sc), .running(a_run)
    );

    // fast instance: one running cycle per second, for the day wrap
    sw_stopwatch #(.PRE_DIV(1), .TICKS(1)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .btn_toggle(b_tog), .btn_clear(b_clr),
        .hours(b_hr), .minutes(b_mn), .seconds(b_sc), .running(b_run)
    );

    typedef struct {
        int    which;
        int    h;
        int    m;
        int    s;
        bit    run;
        string req;
    } exp_t;

    exp_t sb[$];

    task automatic expect_now(input int which, input int h, input int m, input int s,
                              input bit run, input string req);
        exp_t e;
        e.which = which; e.h = h; e.m = m; e.s = s; e.run = run; e.req = req;
        sb.push_back(e);
        #1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive at a falling edge, hold for three rising edges, release
    task automatic press_a(input bit tog, input bit clr, input int hold);
        a_tog = tog; a_clr = clr;
        repeat (hold) @(negedge clk);
        a_tog = 1'b0; a_clr = 1'b0;
    endtask

    task automatic press_b_tog();
        b_tog = 1'b1;
        repeat (3) @(negedge clk);
        b_tog = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (sb.size() != 0);
            begin
                exp_t e;
                int gh, gm, gs;
                bit gr;
                e = sb.pop_front();
                if (e.which == 0) begin gh = a_hr; gm = a_mn; gs = a_sc; gr = a_run; end
                else              begin gh = b_hr; gm = b_mn; gs = b_sc; gr = b_run; end
                checks++;
                if (gh != e.h || gm != e.m || gs != e.s || gr != e.run) begin
                    errors++;
                    $display("FAIL %s dut%0d: got %0d:%0d:%0d run=%0b expected %0d:%0d:%0d run=%0b",
                             e.req, e.which, gh, gm, gs, gr, e.h, e.m, e.s, e.run);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        wait_cyc(4);
        rst_n = 1'b1;
        expect_now(0, 0, 0, 0, 1'b0, "R1 reset state");
        expect_now(1, 0, 0, 0, 1'b0, "R1 reset state fast");
        wait_cyc(30);
        expect_now(0, 0, 0, 0, 1'b0, "R1 stopped until start");

        // start: run seen after third rising edge
        a_tog = 1'b1;
        wait_cyc(2);
        expect_now(0, 0, 0, 0, 1'b0, "R3 not yet toggled");
        wait_cyc(1);
        a_tog = 1'b0;
        expect_now(0, 0, 0, 0, 1'b1, "R3 toggle latency");
        wait_cyc(11);
        expect_now(0, 0, 0, 0, 1'b1, "R2 before first second");
        wait_cyc(1);
        expect_now(0, 0, 0, 1, 1'b1, "R2 exact second");
        wait_cyc(707);
        expect_now(0, 0, 0, 59, 1'b1, "R6 before seconds wrap");
        wait_cyc(1);
        expect_now(0, 0, 1, 0, 1'b1, "R6 seconds wrap carry");

        // pause: three more running edges, then held
        press_a(1'b1, 1'b0, 3);
        expect_now(0, 0, 1, 0, 1'b0, "R3 pause");
        wait_cyc(100);
        expect_now(0, 0, 1, 0, 1'b0, "R4 hold while paused");

        // resume: 9 running cycles remain in this second
        press_a(1'b1, 1'b0, 3);
        wait_cyc(8);
        expect_now(0, 0, 1, 0, 1'b1, "R4 resume fraction kept");
        wait_cyc(1);
        expect_now(0, 0, 1, 1, 1'b1, "R4 resume without loss");

        // clear while running
        wait_cyc(4);
        press_a(1'b0, 1'b1, 3);
        expect_now(0, 0, 0, 0, 1'b1, "R5 clear keeps run");
        wait_cyc(11);
        expect_now(0, 0, 0, 0, 1'b1, "R5 prescaler cleared");
        wait_cyc(1);
        expect_now(0, 0, 0, 1, 1'b1, "R5 full second after clear");

        // simultaneous presses
        wait_cyc(4);
        press_a(1'b1, 1'b1, 3);
        expect_now(0, 0, 0, 0, 1'b1, "R9 clear wins over toggle");
        wait_cyc(12);
        expect_now(0, 0, 0, 1, 1'b1, "R9 still running");

        // long hold: one toggle only
        press_a(1'b1, 1'b0, 25);
        wait_cyc(10);
        expect_now(0, 0, 0, 1, 1'b0, "R10 long hold single toggle");

        // fast instance: carries through a full day
        press_b_tog();
        expect_now(1, 0, 0, 0, 1'b1, "R3 fast start");
        wait_cyc(3599);
        expect_now(1, 0, 59, 59, 1'b1, "R7 before minutes wrap");
        wait_cyc(1);
        expect_now(1, 1, 0, 0, 1'b1, "R7 minutes wrap carry");
        wait_cyc(82799);
        expect_now(1, 23, 59, 59, 1'b1, "R8 last second of day");
        wait_cyc(1);
        expect_now(1, 0, 0, 0, 1'b1, "R8 hours wrap");

        wait (sb.size() == 0);
        #1;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule